// File: doc/BRIEF.md
# Load-Delay Slot Dependency Classifier

This block sits beside the decode stage of a pipelined 32-bit core whose loads have one delay slot. When a load is still filling a register, it looks at the instruction word that occupies the delay slot and reports how that instruction uses the register. The four possible answers are no interaction, read and write, read only, and write only. The pipeline control uses the answer to pick a treatment for the slot. When the slot only writes the register, its result must win over the late load data. When the slot reads the register, the old value must be presented. When the slot both reads and writes it, the slot may be dropped.

A second, independent decoder examines the instruction currently being issued. It flags whether that instruction is a delayed-load type, which means a following slot needs this check. Both results are registered and appear one cycle after the valid strobe. The classifier only decodes. It executes nothing and forwards nothing.

Field positions in an instruction word are fixed: opcode in bits 31:26, rs in 25:21, rt in 20:16, rd in 15:11, function code in 5:0. The relation code on `out_class` is 0 for none, 1 for read-and-write, 2 for read only and 3 for write only. "Matches" below means the field equals `load_reg`.

Top module: `ldc_classifier`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. After a cycle with `in_valid` low, `out_valid`, `out_class` and `out_dload` are all 0.
- R2: While `rst_n` is low at a clock edge, all outputs are cleared to 0.
- R3: An all-zero slot word gives class 0 for every `load_reg`, including register 0.
- R4: For opcode 0 with function 0, 2 or 3, the checks apply in this order. rd and rt both matching gives 1. Otherwise rt matching gives 2. Otherwise rd matching gives 3.
- R5: For opcode 0 with function 4, 6, 7, 0x20–0x27, 0x2A or 0x2B, the checks apply in this order. rd matching together with rs or rt matching gives 1. Otherwise rs or rt matching gives 2. Otherwise rd matching gives 3.
- R6: For opcode 0, the following rules apply. Function 8 gives 2 on an rs match. Function 9 uses the rd/rs order of R5 with rs as the only source. Functions 0x11 and 0x13 give 2 on an rs match. Functions 0x10 and 0x12 give 3 on an rd match. Functions 0x18–0x1B give 2 on an rs or rt match.
- R7: Opcode 3 gives 3 only when `load_reg` is 31. Opcodes 4 and 5 give 2 on an rs or rt match. Opcodes 6 and 7 give 2 on an rs match. Opcode 1 with rt equal to 0x00, 0x02, 0x10 or 0x12 gives 2 on an rs match.
- R8: Opcodes 0x08–0x0E and 0x20, 0x21, 0x23, 0x24, 0x25 follow one order. rt and rs both matching gives 1, then rs alone gives 2, then rt alone gives 3. Opcode 0x0F gives 3 on an rt match.
- R9: Opcodes 0x22 and 0x26 test rt first and give 3 on a match, and otherwise give 2 on an rs match. Opcodes 0x28, 0x29, 0x2A, 0x2B and 0x2E give 2 on an rs or rt match. Opcodes 0x32 and 0x3A give 2 on an rs match.
- R10: These rules apply to opcode 0x10 or 0x12. An rs field of 0 or 2 (move-from, control-from) gives 3 on an rt match. An rs field of 4 or 6 (move-to, control-to) gives 2 on an rt match.
- R11: `out_dload` is 1 when the current word's opcode is 0x20–0x26 or 0x32, or when it is 0x10 or 0x12 with rs field 0 or 2. It is 0 otherwise.
- R12: Any opcode, function code or sub-field not listed above gives class 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Inputs are meaningful this cycle |
| load_reg | input | 5 | Destination index of the pending load |
| slot_word | input | 32 | Instruction word in the load's delay slot |
| cur_word | input | 32 | Instruction word being issued, tested for delayed-load type |
| out_valid | output | 1 | Registered copy of `in_valid` |
| out_class | output | 2 | Registered relation code (0 none, 1 read-write, 2 read, 3 write) |
| out_dload | output | 1 | Registered delayed-load flag for `cur_word` |

## Verification
Some properties are checked on every cycle. These are the one-cycle handshake, the quiet outputs after an idle cycle, and the zero class for the all-zero word. They also cover the link-register rule, the rule that an upper-immediate load never reads and a store never writes, and the delayed-load flag for every load opcode and for the all-zero word. The full priority order of each instruction format can only be shown by the bench. It sweeps every opcode and every function code against field patterns in which rs, rt and rd each match or miss the load register. It also covers the coprocessor sub-fields, the branch sub-codes, and register 0 as the load target.

// File: rtl/ldc_pkg.sv
// Shared types and field geometry for the load-delay slot classifier.
// Assumes a 32-bit word with a 6-bit opcode at the top and 5-bit register fields.
package ldc_pkg;
    localparam int WORD_W = 32;
    localparam int RIDX_W = 5;
    localparam int OPC_W  = 6;
    localparam int FN_W   = 6;
    localparam int RS_LSB = 21;
    localparam int RT_LSB = 16;
    localparam int RD_LSB = 11;

    typedef enum logic [1:0] {
        REL_NONE  = 2'd0,
        REL_BOTH  = 2'd1,
        REL_READ  = 2'd2,
        REL_WRITE = 2'd3
    } rel_t;

    typedef enum logic [1:0] {
        DST_NONE = 2'd0,
        DST_RD   = 2'd1,
        DST_RT   = 2'd2,
        DST_LINK = 2'd3
    } dst_t;

    // Which fields an instruction reads, which one it writes, and whether the
    // write test takes precedence over the combined test.
    typedef struct packed {
        logic src_rs;
        logic src_rt;
        dst_t dst;
        logic write_first;
    } rule_t;

    function automatic rule_t mk_rule(input logic rs_in, input logic rt_in,
                                      input dst_t d, input logic wf);
        rule_t r;
        r.src_rs      = rs_in;
        r.src_rt      = rt_in;
        r.dst         = d;
        r.write_first = wf;
        return r;
    endfunction
endpackage

// File: rtl/ldc_rule_decode.sv
// Maps opcode, function code and sub-fields to a register-usage rule.
// Assumes the word has already been split into fields; unknown encodings give
// an empty rule (no source, no destination).
module ldc_rule_decode
    import ldc_pkg::*;
#(
    parameter int RW = RIDX_W
) (
    input  logic [OPC_W-1:0] opc,
    input  logic [FN_W-1:0]  fn,
    input  logic [RW-1:0]    rs,
    input  logic [RW-1:0]    rt,
    output rule_t            rule
);
    // Purpose: select the usage rule for the decoded instruction format.
    always_comb begin
        rule = mk_rule(1'b0, 1'b0, DST_NONE, 1'b0);
        case (opc) inside
            6'h00: begin
                case (fn) inside
                    6'h00, 6'h02, 6'h03:
                        rule = mk_rule(1'b0, 1'b1, DST_RD, 1'b0);
                    6'h04, 6'h06, 6'h07, [6'h20:6'h27], 6'h2A, 6'h2B:
                        rule = mk_rule(1'b1, 1'b1, DST_RD, 1'b0);
                    6'h08, 6'h11, 6'h13:
                        rule = mk_rule(1'b1, 1'b0, DST_NONE, 1'b0);
                    6'h09:
                        rule = mk_rule(1'b1, 1'b0, DST_RD, 1'b0);
                    6'h10, 6'h12:
                        rule = mk_rule(1'b0, 1'b0, DST_RD, 1'b0);
                    [6'h18:6'h1B]:
                        rule = mk_rule(1'b1, 1'b1, DST_NONE, 1'b0);
                    default: ;
                endcase
            end
            6'h01: begin
                if (rt == 5'h00 || rt == 5'h02 || rt == 5'h10 || rt == 5'h12)
                    rule = mk_rule(1'b1, 1'b0, DST_NONE, 1'b0);
            end
            6'h03:
                rule = mk_rule(1'b0, 1'b0, DST_LINK, 1'b0);
            6'h04, 6'h05:
                rule = mk_rule(1'b1, 1'b1, DST_NONE, 1'b0);
            6'h06, 6'h07, 6'h32, 6'h3A:
                rule = mk_rule(1'b1, 1'b0, DST_NONE, 1'b0);
            [6'h08:6'h0E], 6'h20, 6'h21, 6'h23, 6'h24, 6'h25:
                rule = mk_rule(1'b1, 1'b0, DST_RT, 1'b0);
            6'h0F:
                rule = mk_rule(1'b0, 1'b0, DST_RT, 1'b0);
            6'h10, 6'h12: begin
                if (rs == 5'h00 || rs == 5'h02)
                    rule = mk_rule(1'b0, 1'b0, DST_RT, 1'b0);
                else if (rs == 5'h04 || rs == 5'h06)
                    rule = mk_rule(1'b0, 1'b1, DST_NONE, 1'b0);
            end
            6'h22, 6'h26:
                rule = mk_rule(1'b1, 1'b0, DST_RT, 1'b1);
            6'h28, 6'h29, 6'h2A, 6'h2B, 6'h2E:
                rule = mk_rule(1'b1, 1'b1, DST_NONE, 1'b0);
            default: ;
        endcase
    end
endmodule

// File: rtl/ldc_rule_apply.sv
// Compares the fields named by a usage rule against the pending load register
// and resolves read/write hits into a relation code.
// Assumes the rule is stable within the cycle; purely combinational.
module ldc_rule_apply
    import ldc_pkg::*;
#(
    parameter int RW       = RIDX_W,
    parameter int LINK_REG = 31
) (
    input  rule_t         rule,
    input  logic [RW-1:0] rs,
    input  logic [RW-1:0] rt,
    input  logic [RW-1:0] rd,
    input  logic [RW-1:0] lreg,
    output rel_t          rel
);
    logic hit_w;
    logic hit_r;

    // Purpose: detect whether the destination named by the rule is the load register.
    always_comb begin
        case (rule.dst)
            DST_RD:   hit_w = (rd == lreg);
            DST_RT:   hit_w = (rt == lreg);
            DST_LINK: hit_w = (lreg == RW'(LINK_REG));
            default:  hit_w = 1'b0;
        endcase
    end

    // Purpose: detect whether any source named by the rule is the load register.
    always_comb hit_r = (rule.src_rs && rs == lreg) || (rule.src_rt && rt == lreg);

    // Purpose: resolve hits into a relation using the rule's precedence.
    always_comb begin
        if (rule.write_first)
            rel = hit_w ? REL_WRITE : (hit_r ? REL_READ : REL_NONE);
        else if (hit_w && hit_r)
            rel = REL_BOTH;
        else if (hit_r)
            rel = REL_READ;
        else if (hit_w)
            rel = REL_WRITE;
        else
            rel = REL_NONE;
    end
endmodule

// File: rtl/ldc_dload_detect.sv
// Flags instruction words that are delayed loads (memory loads, coprocessor
// load, coprocessor move-from and control-from).
// Assumes opcode and rs positions fixed by ldc_pkg.
module ldc_dload_detect
    import ldc_pkg::*;
#(
    parameter int WW = WORD_W
) (
    input  logic [WW-1:0] word,
    output logic          hit
);
    logic [OPC_W-1:0]  opc;
    logic [RIDX_W-1:0] rs;
    logic              unused_bits;

    assign opc         = word[WW-1 -: OPC_W];
    assign rs          = word[RS_LSB +: RIDX_W];
    assign unused_bits = ^word[RS_LSB-1:0];

    // Purpose: recognise the delayed-load encodings.
    always_comb begin
        case (opc) inside
            [6'h20:6'h26], 6'h32: hit = 1'b1;
            6'h10, 6'h12:         hit = (rs == 5'h00) || (rs == 5'h02);
            default:              hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/ldc_classifier.sv
// Top of the load-delay slot classifier: decodes the slot word against the
// pending load register and flags delayed-load current words; results are
// registered one cycle after the valid strobe.
// Assumes a synchronous active-low reset and one slot query per cycle.
module ldc_classifier
    import ldc_pkg::*;
#(
    parameter int WW       = WORD_W,
    parameter int RW       = RIDX_W,
    parameter int LINK_REG = 31
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [RW-1:0] load_reg,
    input  logic [WW-1:0] slot_word,
    input  logic [WW-1:0] cur_word,
    output logic          out_valid,
    output logic [1:0]    out_class,
    output logic          out_dload
);
    logic [OPC_W-1:0] opc;
    logic [FN_W-1:0]  fn;
    logic [RW-1:0]    f_rs;
    logic [RW-1:0]    f_rt;
    logic [RW-1:0]    f_rd;
    logic             is_nop;
    rule_t            rule;
    rel_t             rel;
    logic             dl_hit;

    assign opc    = slot_word[WW-1 -: OPC_W];
    assign fn     = slot_word[FN_W-1:0];
    assign f_rs   = slot_word[RS_LSB +: RW];
    assign f_rt   = slot_word[RT_LSB +: RW];
    assign f_rd   = slot_word[RD_LSB +: RW];
    assign is_nop = (slot_word == '0);

    ldc_rule_decode #(.RW(RW)) u_decode (
        .opc  (opc),
        .fn   (fn),
        .rs   (f_rs),
        .rt   (f_rt),
        .rule (rule)
    );

    ldc_rule_apply #(.RW(RW), .LINK_REG(LINK_REG)) u_apply (
        .rule (rule),
        .rs   (f_rs),
        .rt   (f_rt),
        .rd   (f_rd),
        .lreg (load_reg),
        .rel  (rel)
    );

    ldc_dload_detect #(.WW(WW)) u_dload (
        .word (cur_word),
        .hit  (dl_hit)
    );

    // Purpose: register the relation and detector flag, cleared when idle or in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_class <= REL_NONE;
            out_dload <= 1'b0;
        end else begin
            out_valid <= in_valid;
            out_class <= (in_valid && !is_nop) ? rel : REL_NONE;
            out_dload <= in_valid && dl_hit;
        end
    end
endmodule

// File: rtl/ldc_classifier_chk.sv
// Property checker for ldc_classifier, attached by bind.
// Assumes the top's port names; observes only, drives nothing.
module ldc_classifier_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [4:0]  load_reg,
    input logic [31:0] slot_word,
    input logic [31:0] cur_word,
    input logic        out_valid,
    input logic [1:0]  out_class,
    input logic        out_dload
);
    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && out_class == 2'd0 && !out_dload));

    assert_zero_word_none_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && slot_word == 32'h0) |=> out_class == 2'd0);

    assert_link_only_r31_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && slot_word[31:26] == 6'h03) |=>
            out_class == (($past(load_reg) == 5'd31) ? 2'd3 : 2'd0));

    assert_upper_imm_no_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && slot_word[31:26] == 6'h0F) |=> (out_class == 2'd0 || out_class == 2'd3));

    assert_store_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && slot_word[31:26] inside {6'h28, 6'h29, 6'h2A, 6'h2B, 6'h2E})
            |=> (out_class == 2'd0 || out_class == 2'd2));

    assert_load_flagged_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cur_word[31:26] inside {[6'h20:6'h26]}) |=> out_dload);

    assert_zero_word_unflagged_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_word == 32'h0) |=> !out_dload);
endmodule

bind ldc_classifier ldc_classifier_chk u_chk (.*);

// File: tb/tb_ldc_classifier.sv
`timescale 1ns/1ps
module tb_ldc_classifier;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [4:0]  load_reg;
    logic [31:0] slot_word;
    logic [31:0] cur_word;
    logic        out_valid;
    logic [1:0]  out_class;
    logic        out_dload;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    ldc_classifier dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .load_reg(load_reg),
        .slot_word(slot_word), .cur_word(cur_word),
        .out_valid(out_valid), .out_class(out_class), .out_dload(out_dload)
    );

    // Independent reference of the requirement text.
    function automatic logic [1:0] ref_class(input logic [31:0] w, input logic [4:0] r);
        logic [5:0] op = w[31:26];
        logic [5:0] fn = w[5:0];
        logic ms = (w[25:21] == r);
        logic mt = (w[20:16] == r);
        logic md = (w[15:11] == r);
        logic [4:0] rsv = w[25:21];
        logic [4:0] rtv = w[20:16];
        if (w == 32'h0) return 2'd0;
        if (op == 6'h00) begin
            if (fn == 6'h00 || fn == 6'h02 || fn == 6'h03) begin
                if (md && mt) return 2'd1;
                if (mt) return 2'd2;
                if (md) return 2'd3;
                return 2'd0;
            end
            if (fn == 6'h04 || fn == 6'h06 || fn == 6'h07 || (fn >= 6'h20 && fn <= 6'h27)
                || fn == 6'h2A || fn == 6'h2B) begin
                if (md && (ms || mt)) return 2'd1;
                if (ms || mt) return 2'd2;
                if (md) return 2'd3;
                return 2'd0;
            end
            if (fn == 6'h08 || fn == 6'h11 || fn == 6'h13) return ms ? 2'd2 : 2'd0;
            if (fn == 6'h09) begin
                if (md && ms) return 2'd1;
                if (ms) return 2'd2;
                if (md) return 2'd3;
                return 2'd0;
            end
            if (fn == 6'h10 || fn == 6'h12) return md ? 2'd3 : 2'd0;
            if (fn >= 6'h18 && fn <= 6'h1B) return (ms || mt) ? 2'd2 : 2'd0;
            return 2'd0;
        end
        if (op == 6'h01)
            return ((rtv == 5'h00 || rtv == 5'h02 || rtv == 5'h10 || rtv == 5'h12) && ms) ? 2'd2 : 2'd0;
        if (op == 6'h03) return (r == 5'd31) ? 2'd3 : 2'd0;
        if (op == 6'h04 || op == 6'h05) return (ms || mt) ? 2'd2 : 2'd0;
        if (op == 6'h06 || op == 6'h07) return ms ? 2'd2 : 2'd0;
        if ((op >= 6'h08 && op <= 6'h0E) || op == 6'h20 || op == 6'h21 || op == 6'h23
            || op == 6'h24 || op == 6'h25) begin
            if (mt && ms) return 2'd1;
            if (ms) return 2'd2;
            if (mt) return 2'd3;
            return 2'd0;
        end
        if (op == 6'h0F) return mt ? 2'd3 : 2'd0;
        if (op == 6'h10 || op == 6'h12) begin
            if (rsv == 5'h00 || rsv == 5'h02) return mt ? 2'd3 : 2'd0;
            if (rsv == 5'h04 || rsv == 5'h06) return mt ? 2'd2 : 2'd0;
            return 2'd0;
        end
        if (op == 6'h22 || op == 6'h26) begin
            if (mt) return 2'd3;
            if (ms) return 2'd2;
            return 2'd0;
        end
        if (op == 6'h28 || op == 6'h29 || op == 6'h2A || op == 6'h2B || op == 6'h2E)
            return (ms || mt) ? 2'd2 : 2'd0;
        if (op == 6'h32 || op == 6'h3A) return ms ? 2'd2 : 2'd0;
        return 2'd0;
    endfunction

    function automatic logic ref_dload(input logic [31:0] w);
        logic [5:0] op = w[31:26];
        logic [4:0] s  = w[25:21];
        if (op >= 6'h20 && op <= 6'h26) return 1'b1;
        if (op == 6'h32) return 1'b1;
        if ((op == 6'h10 || op == 6'h12) && (s == 5'h00 || s == 5'h02)) return 1'b1;
        return 1'b0;
    endfunction

    function automatic string ref_tag(input logic [31:0] w);
        logic [5:0] op = w[31:26];
        logic [5:0] fn = w[5:0];
        logic [4:0] s  = w[25:21];
        logic [4:0] t  = w[20:16];
        if (w == 32'h0) return "R3";
        if (op == 6'h00) begin
            if (fn == 6'h00 || fn == 6'h02 || fn == 6'h03) return "R4";
            if (fn == 6'h04 || fn == 6'h06 || fn == 6'h07 || (fn >= 6'h20 && fn <= 6'h27)
                || fn == 6'h2A || fn == 6'h2B) return "R5";
            if (fn == 6'h08 || fn == 6'h09 || (fn >= 6'h10 && fn <= 6'h13)
                || (fn >= 6'h18 && fn <= 6'h1B)) return "R6";
            return "R12";
        end
        if (op == 6'h01)
            return (t == 5'h00 || t == 5'h02 || t == 5'h10 || t == 5'h12) ? "R7" : "R12";
        if (op >= 6'h03 && op <= 6'h07) return "R7";
        if (op >= 6'h08 && op <= 6'h0F) return "R8";
        if (op == 6'h20 || op == 6'h21 || op == 6'h23 || op == 6'h24 || op == 6'h25) return "R8";
        if (op == 6'h22 || op == 6'h26 || op == 6'h28 || op == 6'h29 || op == 6'h2A
            || op == 6'h2B || op == 6'h2E || op == 6'h32 || op == 6'h3A) return "R9";
        if ((op == 6'h10 || op == 6'h12) && (s == 5'h00 || s == 5'h02 || s == 5'h04 || s == 5'h06))
            return "R10";
        return "R12";
    endfunction

    // Drive one query just after a falling edge, then check at the next falling edge.
    task automatic run_vec(input logic v, input logic [4:0] r,
                           input logic [31:0] sw, input logic [31:0] cw);
        logic [1:0] ec;
        logic       ed;
        string      tag;
        in_valid  = v;
        load_reg  = r;
        slot_word = sw;
        cur_word  = cw;
        ec  = v ? ref_class(sw, r) : 2'd0;
        ed  = v ? ref_dload(cw) : 1'b0;
        tag = v ? ref_tag(sw) : "R1";
        @(negedge clk);
        checks++;
        if (out_valid !== v || out_class !== ec) begin
            errors++;
            $display("FAIL %s word=%h reg=%0d: valid=%0b class=%0d expected valid=%0b class=%0d",
                     tag, sw, r, out_valid, out_class, v, ec);
        end
        checks++;
        if (out_dload !== ed) begin
            errors++;
            $display("FAIL %s detector word=%h: got %0b expected %0b",
                     v ? "R11" : "R1", cw, out_dload, ed);
        end
    endtask

    function automatic logic [31:0] pack(input logic [5:0] op, input logic [4:0] s,
                                         input logic [4:0] t, input logic [4:0] d,
                                         input logic [5:0] fn);
        return {op, s, t, d, 5'h0A, fn};
    endfunction

    initial begin
        rst_n = 1'b0; in_valid = 1'b1; load_reg = 5'd3;
        slot_word = pack(6'h00, 5'd3, 5'd3, 5'd3, 6'h21);
        cur_word  = 32'h8C00_0000;
        repeat (3) @(negedge clk);
        // R2: outputs held clear during reset despite active inputs
        checks++;
        if (out_valid !== 1'b0 || out_class !== 2'd0 || out_dload !== 1'b0) begin
            errors++;
            $display("FAIL R2 reset: valid=%0b class=%0d dload=%0b expected 0 0 0",
                     out_valid, out_class, out_dload);
        end
        rst_n = 1'b1;
        // R1: idle cycle hides a word that would classify
        run_vec(1'b0, 5'd3, pack(6'h00, 5'd3, 5'd3, 5'd3, 6'h21), 32'h8C00_0000);
        // R3: all-zero word with register 0
        run_vec(1'b1, 5'd0, 32'h0, 32'h0);
        run_vec(1'b1, 5'd31, 32'h0, 32'h0);
        // Main sweep: every opcode, function and sub-field against match patterns.
        foreach (dut.WW[i]) ;
        for (int ri = 0; ri < 4; ri++) begin
            logic [4:0] a, b, c, d;
            logic [4:0] fs [8];
            logic [4:0] ft [8];
            logic [4:0] fd [8];
            case (ri)
                0: a = 5'd0;
                1: a = 5'd5;
                2: a = 5'd31;
                default: a = 5'd17;
            endcase
            b = a ^ 5'd1; c = a ^ 5'd2; d = a ^ 5'd3;
            fs = '{a, a, b, b, a, a, b, b};
            ft = '{a, b, a, c, a, b, a, c};
            fd = '{a, c, c, a, c, a, a, d};
            for (int op = 0; op < 64; op++) begin
                if (op == 0) begin
                    for (int fn = 0; fn < 64; fn++)
                        for (int k = 0; k < 8; k++) begin
                            logic [31:0] w;
                            w = pack(6'(op), fs[k], ft[k], fd[k], 6'(fn));
                            run_vec(1'b1, a, w, w);
                        end
                end else if (op == 1) begin
                    for (int sub = 0; sub < 6; sub++)
                        for (int k = 0; k < 2; k++) begin
                            logic [4:0] tv;
                            logic [31:0] w;
                            case (sub)
                                0: tv = 5'h00; 1: tv = 5'h02; 2: tv = 5'h10;
                                3: tv = 5'h12; 4: tv = 5'h01; default: tv = 5'h03;
                            endcase
                            w = pack(6'h01, k == 0 ? a : b, tv, c, 6'h00);
                            run_vec(1'b1, a, w, w);
                        end
                end else if (op == 6'h10 || op == 6'h12) begin
                    for (int sub = 0; sub < 8; sub++)
                        for (int k = 0; k < 2; k++) begin
                            logic [31:0] w;
                            w = pack(6'(op), 5'(sub), k == 0 ? a : b, a, 6'h00);
                            run_vec(1'b1, a, w, w);
                        end
                end else begin
                    for (int k = 0; k < 8; k++) begin
                        logic [31:0] w;
                        w = pack(6'(op), fs[k], ft[k], fd[k], 6'h05);
                        run_vec(1'b1, a, w, w);
                    end
                end
            end
        end
        // R11: detector operates on cur_word independently of the slot word
        run_vec(1'b1, 5'd7, 32'h0, pack(6'h32, 5'd1, 5'd7, 5'd2, 6'h00));
        run_vec(1'b1, 5'd7, 32'h0, pack(6'h12, 5'h04, 5'd7, 5'd2, 6'h00));
        run_vec(1'b1, 5'd7, 32'h0, pack(6'h27, 5'd1, 5'd7, 5'd2, 6'h00));
        // R1: return to idle after a burst
        run_vec(1'b0, 5'd7, pack(6'h0F, 5'd0, 5'd7, 5'd0, 6'h00), 32'h8C00_0000);
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #600000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, got hung expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule